// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which of five UART interrupt conditions is shown to software and produces the encoded identification value and the interrupt line. Line status, receive data available, character timeout and modem status arrive as levels from neighbouring logic and are shown while they are high. The transmit-empty source is held inside the block. It is raised by a rising edge of the holding-register-empty level and dropped by a write to the holding register, or by a read of the identification value that reports it.

The read clear is selective. A read removes transmit-empty only when that source is the value being returned in the same cycle. A transmit-empty edge that lands in the read cycle wins over the clear, so a new event is never lost. Each source has its own enable bit. Disabled sources stay latched but are neither reported nor allowed to assert the interrupt.

Top module: `uart_iid`

## Requirements
- R1: After reset the identification value is 0x1 and the interrupt output is low, and no transmit-empty is pending.
- R2: Priority from highest to lowest is line status, receive data available, character timeout, transmit-empty, modem status. The identification value is {code[2:0], 0}, with code 011 line status (0x6), 010 data available (0x4), 110 timeout (0xC), 001 transmit-empty (0x2) and 000 modem status (0x0). With nothing reported it is 0x1.
- R3: Enable bits int_en_i[0..4] belong to line status, data available, timeout, transmit-empty and modem status in that order. A source whose bit is 0 is not reported.
- R4: Transmit-empty becomes pending on the clock edge after a cycle in which thr_empty_i is high and was low in the previous cycle. It does not become pending while the level simply stays high.
- R5: A read (iid_rd_i high) in a cycle where the value shows 0x2 clears transmit-empty from the next cycle on.
- R6: A read while a higher-priority source is reported leaves transmit-empty pending.
- R7: A transmit-empty rising edge in the same cycle as a clearing read or a holding-register write leaves transmit-empty pending.
- R8: A holding-register write (thr_wr_i high) clears transmit-empty on the next edge.
- R9: irq_o is high exactly when some enabled source is pending, which is the same as identification bit 0 being 0.
- R10: The four level sources show up in the same cycle without registering, and a read does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_en_i | input | 5 | Per-source enables (see R3) |
| line_stat_i | input | 1 | Receive line status condition (level) |
| rx_avail_i | input | 1 | Receive data available condition (level) |
| char_tout_i | input | 1 | Character timeout condition (level) |
| thr_empty_i | input | 1 | Transmit holding register empty (level) |
| thr_wr_i | input | 1 | Write strobe to the transmit holding register |
| modem_stat_i | input | 1 | Modem status change condition (level) |
| iid_rd_i | input | 1 | Read strobe of the identification value |
| iid_o | output | 4 | Encoded identification value |
| irq_o | output | 1 | Interrupt request |

## Verification
The two functions that can fall in the same cycle are the read clear of transmit-empty and the hardware setting of it, through a fresh empty edge. A holding-register write can also land on that same edge. The bench provokes the race on purpose: it drops thr_empty_i for one cycle while transmit-empty is reported, then raises it again in the cycle of the read. It checks on the following cycles that 0x2 is still reported. A behavioural reference model runs alongside under directed and random stimulus, and every cycle the value and the interrupt line are compared with it.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;
  localparam int NUM_SRC = 5;
  localparam int CODE_W  = 3;
  localparam int ID_W    = CODE_W + 1;

  // source index = priority rank, 0 highest
  localparam int IDX_LINE  = 0;
  localparam int IDX_RXAV  = 1;
  localparam int IDX_TOUT  = 2;
  localparam int IDX_TXE   = 3;
  localparam int IDX_MODEM = 4;

  localparam logic [ID_W-1:0] ID_NONE = 4'h1;

  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      IDX_LINE: return 3'b011;
      IDX_RXAV: return 3'b010;
      IDX_TOUT: return 3'b110;
      IDX_TXE:  return 3'b001;
      default:  return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/uart_iid_edge.sv
module uart_iid_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  // prev resets high: a level already high out of reset is not an event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/uart_iid_txe_pend.sv
module uart_iid_txe_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_wr_i,
  input  logic clr_rd_i,
  output logic pend_o
);
  // set wins over both clears so a coincident event is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pend_o <= 1'b0;
    else if (set_i)               pend_o <= 1'b1;
    else if (clr_wr_i | clr_rd_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
  import uart_iid_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]    pend_i,
  input  logic [N-1:0]    en_i,
  output logic [ID_W-1:0] id_o,
  output logic [N-1:0]    sel_o
);
  logic [N-1:0] act;
  assign act = pend_i & en_i;

  // walk lowest to highest rank; the last hit has the highest priority
  always_comb begin
    id_o  = ID_NONE;
    sel_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) begin
        id_o     = {src_code(i), 1'b0};
        sel_o    = '0;
        sel_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_iid.sv
module uart_iid
  import uart_iid_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] int_en_i,
  input  logic               line_stat_i,
  input  logic               rx_avail_i,
  input  logic               char_tout_i,
  input  logic               thr_empty_i,
  input  logic               thr_wr_i,
  input  logic               modem_stat_i,
  input  logic               iid_rd_i,
  output logic [ID_W-1:0]    iid_o,
  output logic               irq_o
);
  logic               txe_rise;
  logic               txe_pend;
  logic [NUM_SRC-1:0] pend_vec;
  logic [NUM_SRC-1:0] sel;

  uart_iid_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (thr_empty_i),
    .rise_o (txe_rise)
  );

  uart_iid_txe_pend u_txe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (txe_rise),
    .clr_wr_i (thr_wr_i),
    .clr_rd_i (iid_rd_i & sel[IDX_TXE]),
    .pend_o   (txe_pend)
  );

  always_comb begin
    pend_vec            = '0;
    pend_vec[IDX_LINE]  = line_stat_i;
    pend_vec[IDX_RXAV]  = rx_avail_i;
    pend_vec[IDX_TOUT]  = char_tout_i;
    pend_vec[IDX_TXE]   = txe_pend;
    pend_vec[IDX_MODEM] = modem_stat_i;
  end

  uart_iid_prio #(.N(NUM_SRC)) u_prio (
    .pend_i (pend_vec),
    .en_i   (int_en_i),
    .id_o   (iid_o),
    .sel_o  (sel)
  );

  assign irq_o = |(pend_vec & int_en_i);
endmodule

// File: rtl/uart_iid_chk.sv
module uart_iid_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       iid_rd_i,
  input logic       thr_wr_i,
  input logic [3:0] iid_o,
  input logic       irq_o,
  input logic       txe_pend,
  input logic       txe_rise
);
  // R5
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iid_rd_i && iid_o == 4'h2 && !txe_rise) |=> !txe_pend);

  // R6
  rd_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iid_rd_i && iid_o != 4'h2 && !thr_wr_i && !txe_rise) |=> $stable(txe_pend));

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txe_rise |=> txe_pend);

  // R8
  wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr_i && !txe_rise) |=> !txe_pend);

  // R9
  irq_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !iid_o[0]);

  // R2
  none_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> iid_o == 4'h1);
endmodule

bind uart_iid uart_iid_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .iid_rd_i (iid_rd_i),
  .thr_wr_i (thr_wr_i),
  .iid_o    (iid_o),
  .irq_o    (irq_o),
  .txe_pend (txe_pend),
  .txe_rise (txe_rise)
);

// File: tb/uart_iid_tb_top.sv
module uart_iid_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] int_en_i = '0;
  logic       line_stat_i = 0, rx_avail_i = 0, char_tout_i = 0;
  logic       thr_empty_i = 0, thr_wr_i = 0, modem_stat_i = 0, iid_rd_i = 0;
  logic [3:0] iid_o;
  logic       irq_o;

  int n_run = 0, n_fail = 0;
  bit m_txe = 0, m_prev = 1;

  always #10 clk_i = ~clk_i;

  uart_iid dut_i (.*);

  function automatic logic [3:0] exp_id();
    if (int_en_i[0] && line_stat_i)  return 4'h6;
    if (int_en_i[1] && rx_avail_i)   return 4'h4;
    if (int_en_i[2] && char_tout_i)  return 4'hC;
    if (int_en_i[3] && m_txe)        return 4'h2;
    if (int_en_i[4] && modem_stat_i) return 4'h0;
    return 4'h1;
  endfunction

  // compare now, then advance one clock with the model
  task automatic cyc(input string tag);
    logic [3:0] e;
    #1;
    e = exp_id();
    n_run++;
    if (iid_o !== e || irq_o !== (e != 4'h1)) begin
      n_fail++;
      $display("FAIL %s: id=%h irq=%b expected id=%h irq=%b", tag, iid_o, irq_o, e, e != 4'h1);
    end
    @(posedge clk_i);
    begin
      bit rise;
      bit clr;
      rise = thr_empty_i && !m_prev;
      clr  = thr_wr_i || (iid_rd_i && e == 4'h2);
      if (rise) m_txe = 1;
      else if (clr) m_txe = 0;
      m_prev = thr_empty_i;
    end
    @(negedge clk_i);
    iid_rd_i = 0;
    thr_wr_i = 0;
  endtask

  task automatic txe_edge();
    thr_empty_i = 0; cyc("R4");
    thr_empty_i = 1; cyc("R4");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk_i);
    int_en_i = 5'h1F;
    cyc("R1");
    rst_ni = 1;
    cyc("R1");
    thr_empty_i = 1; cyc("R1"); // level high since reset: no event (R4)
    cyc("R4");

    // R2 priority walk with all sources pending
    txe_edge(); cyc("R4");
    line_stat_i = 1; rx_avail_i = 1; char_tout_i = 1; modem_stat_i = 1;
    cyc("R2");
    line_stat_i = 0; cyc("R2");
    rx_avail_i = 0;  cyc("R2");
    char_tout_i = 0; cyc("R2");
    // R3 enables mask sources
    int_en_i = 5'b10111; cyc("R3");
    int_en_i = 5'b00111; cyc("R3");
    int_en_i = 5'h1F; cyc("R3");

    // R6 read while rx data outranks transmit-empty
    rx_avail_i = 1; iid_rd_i = 1; cyc("R6");
    rx_avail_i = 0; cyc("R6");
    // R10 read does not drop level sources
    line_stat_i = 1; iid_rd_i = 1; cyc("R10");
    cyc("R10");
    line_stat_i = 0; cyc("R10");

    // R5 read reporting transmit-empty clears it
    iid_rd_i = 1; cyc("R5");
    cyc("R5");
    modem_stat_i = 0; cyc("R5");

    // R7 read coinciding with a fresh edge
    txe_edge(); cyc("R7");
    thr_empty_i = 0; cyc("R7");
    thr_empty_i = 1; iid_rd_i = 1; cyc("R7");
    cyc("R7");
    cyc("R7");

    // R8 write clears; write with edge keeps it
    thr_wr_i = 1; thr_empty_i = 0; cyc("R8");
    cyc("R8");
    thr_empty_i = 1; thr_wr_i = 1; cyc("R7");
    cyc("R7");
    thr_wr_i = 1; cyc("R8");
    cyc("R8");

    // R9 random mix
    for (int i = 0; i < 400; i++) begin
      int_en_i     = 5'($urandom);
      line_stat_i  = ($urandom % 5) == 0;
      rx_avail_i   = ($urandom % 4) == 0;
      char_tout_i  = ($urandom % 4) == 0;
      modem_stat_i = ($urandom % 3) == 0;
      thr_empty_i  = 1'($urandom);
      thr_wr_i     = ($urandom % 5) == 0;
      iid_rd_i     = 1'($urandom);
      cyc("R9");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule